// File: doc/BRIEF.md
# Packet-Atomic Transmit Port Arbiter

This block shares one outbound packet stream among several packet producers. There are a parameterised number of bulk data-mover channels (eight by default), one source of register-read completions, and, when the build enables it, one source of memory read requests. Each producer offers whole packets on its own valid/ready/last stream. The arbiter connects one producer to the shared port and forwards its beats unchanged, with the port's backpressure passed back to that producer. It chooses again only when a packet has finished.

The selection order is fixed. Completions come first, so that register reads never wait behind bulk traffic. Read requests come second. The data-mover channels take turns in rotating order. The data path has no registers. When the port is idle, a packet that is offered reaches the port in the same cycle, and a new packet can follow a finished one with no gap cycle.

Top module: `tx_port_arbiter`

## Requirements
- R1: When no producer offers a packet, `m_tvalid` is low and every producer ready output is low, including straight after reset.
- R2: At a packet boundary, a completion that is offered (`cpl_tvalid` high) wins over every other producer.
- R3: At a packet boundary with no completion offered, an offered read request wins over every data-mover channel.
- R4: Data-mover channels are served in rotating order. After reset the search starts at channel 0. When a channel's packet ends, the search starts at the next channel, and after the highest channel it wraps to 0.
- R5: Once a packet has started, the grant stays with its producer until the beat carrying `m_tlast` is accepted, even if a producer of higher priority becomes valid.
- R6: Once a beat is offered on the port and not yet accepted, the selection does not change, and `m_tdata`/`m_tlast` stay stable while the producer holds its beat.
- R7: Only the selected producer's ready output follows `m_tready`. Every other ready output is low, so at most one ready output is high at any time.
- R8: With `HAS_RDREQ` = 0, the read-request input is ignored. `rrq_tready` stays low and an offered request never reaches the port.
- R9: The port carries the selected producer's data and last flag in the same cycle. After a packet's last beat, the next packet's first beat can be accepted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_tdata | input | NUM_DMA*DW | Data of each data-mover channel; channel i at bits [i*DW +: DW] |
| dma_tvalid | input | NUM_DMA | Beat valid, one bit per channel |
| dma_tlast | input | NUM_DMA | Last beat of packet, one bit per channel |
| dma_tready | output | NUM_DMA | Beat accepted, one bit per channel |
| cpl_tdata | input | DW | Completion data |
| cpl_tvalid | input | 1 | Completion beat valid |
| cpl_tlast | input | 1 | Completion last beat |
| cpl_tready | output | 1 | Completion beat accepted |
| rrq_tdata | input | DW | Read-request data |
| rrq_tvalid | input | 1 | Read-request beat valid |
| rrq_tlast | input | 1 | Read-request last beat |
| rrq_tready | output | 1 | Read-request beat accepted |
| m_tdata | output | DW | Shared port data |
| m_tvalid | output | 1 | Shared port beat valid |
| m_tlast | output | 1 | Shared port last beat |
| m_tready | input | 1 | Shared port accepts the beat |

## Verification
The stability check on the shared port assumes the normal stream rule on every producer: once a producer raises valid, it keeps valid, data and last unchanged until its ready is seen high. The packet-boundary checks also assume that each producer ends its packets with a last beat. The bench's producer models follow both rules. Each model changes its beat only on a handshake at a clock edge, and each packet it launches has a fixed length whose final beat carries last. All inputs change one time unit after the rising edge, and the bench samples on the falling edge.

// File: rtl/tx_port_arbiter.sv
module tx_port_arbiter #(
  parameter int NUM_DMA   = 8,
  parameter int DW        = 64,
  parameter bit HAS_RDREQ = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DMA*DW-1:0] dma_tdata,
  input  logic [NUM_DMA-1:0]    dma_tvalid,
  input  logic [NUM_DMA-1:0]    dma_tlast,
  output logic [NUM_DMA-1:0]    dma_tready,
  input  logic [DW-1:0]         cpl_tdata,
  input  logic                  cpl_tvalid,
  input  logic                  cpl_tlast,
  output logic                  cpl_tready,
  input  logic [DW-1:0]         rrq_tdata,
  input  logic                  rrq_tvalid,
  input  logic                  rrq_tlast,
  output logic                  rrq_tready,
  output logic [DW-1:0]         m_tdata,
  output logic                  m_tvalid,
  output logic                  m_tlast,
  input  logic                  m_tready
);

  localparam int NSRC = NUM_DMA + 2;
  localparam int SW   = $clog2(NSRC);
  localparam int PW   = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1;
  localparam int CPL  = NUM_DMA;
  localparam int RRQ  = NUM_DMA + 1;

  logic [NSRC-1:0] vld, lst, rdy;
  logic [DW-1:0]   dat [NSRC];
  logic [PW-1:0]   ptr, rr_idx;
  logic            rr_hit, pick_v, locked, act, xfer;
  logic [SW-1:0]   pick, held, sel;

  for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma
    assign vld[g] = dma_tvalid[g];
    assign lst[g] = dma_tlast[g];
    assign dat[g] = dma_tdata[g*DW +: DW];
  end

  assign vld[CPL] = cpl_tvalid;
  assign lst[CPL] = cpl_tlast;
  assign dat[CPL] = cpl_tdata;

  if (HAS_RDREQ) begin : g_rrq
    assign vld[RRQ] = rrq_tvalid;
    assign lst[RRQ] = rrq_tlast;
    assign dat[RRQ] = rrq_tdata;
  end else begin : g_no_rrq
    assign vld[RRQ] = 1'b0;
    assign lst[RRQ] = 1'b0;
    assign dat[RRQ] = '0;
  end

  always_comb begin
    rr_hit = 1'b0;
    rr_idx = '0;
    for (int k = 0; k < NUM_DMA; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NUM_DMA) j = j - NUM_DMA;
      if (!rr_hit && vld[j]) begin
        rr_hit = 1'b1;
        rr_idx = PW'(j);
      end
    end
  end

  always_comb begin
    if (vld[CPL])      pick = SW'(CPL);
    else if (vld[RRQ]) pick = SW'(RRQ);
    else               pick = SW'(rr_idx);
  end

  assign pick_v   = vld[CPL] | vld[RRQ] | rr_hit;
  assign sel      = locked ? held : pick;
  assign act      = locked | pick_v;
  assign m_tvalid = act & vld[sel];
  assign m_tdata  = dat[sel];
  assign m_tlast  = lst[sel];
  assign xfer     = m_tvalid & m_tready;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      rdy[i] = act && (sel == SW'(i)) && m_tready;
  end

  assign dma_tready = rdy[NUM_DMA-1:0];
  assign cpl_tready = rdy[CPL];
  assign rrq_tready = rdy[RRQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      held   <= '0;
    end else if (xfer && m_tlast) begin
      locked <= 1'b0;
    end else if (m_tvalid) begin
      locked <= 1'b1;
      held   <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (xfer && m_tlast && (int'(sel) < NUM_DMA))
      ptr <= (int'(sel) == NUM_DMA - 1) ? '0 : PW'(int'(sel) + 1);
  end

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rrq_tready, cpl_tready, dma_tready}));

  // R7
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{rrq_tready, cpl_tready, dma_tready}) |-> m_tready);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R2
  cpl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && cpl_tvalid) |-> (m_tvalid && cpl_tready == m_tready && m_tdata == cpl_tdata));

  // R5
  atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && !m_tlast && !cpl_tready) |=> !cpl_tready);

  if (!HAS_RDREQ) begin : g_rrq_off_chk
    // R8
    always_comb rrq_off_chk: assert (!rrq_tready);
  end

endmodule

// File: tb/tb_tx_port_arbiter.sv
module tb_tx_port_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N+1:0] s_valid = '0;
  int           s_left [N+2];
  logic [7:0]   s_beat [N+2];
  logic [N+1:0] s_last, rdy;

  logic [N*DW-1:0] dma_tdata;
  logic [DW-1:0]   cpl_tdata, rrq_tdata, m_tdata;
  logic [N-1:0]    dma_tready;
  logic            cpl_tready, rrq_tready, m_tvalid, m_tlast;
  logic            m_tready = 1'b0;

  for (genvar g = 0; g < N + 2; g++) begin : g_src
    assign s_last[g] = (s_left[g] == 1);
  end
  for (genvar g = 0; g < N; g++) begin : g_dd
    assign dma_tdata[g*DW +: DW] = {48'h0, 8'(g), s_beat[g]};
  end
  assign cpl_tdata = {48'h0, 8'(N), s_beat[N]};
  assign rrq_tdata = {48'h0, 8'(N+1), s_beat[N+1]};
  assign rdy = {rrq_tready, cpl_tready, dma_tready};

  tx_port_arbiter #(.NUM_DMA(N), .DW(DW), .HAS_RDREQ(1'b1)) dut (
    .clk, .rst_n,
    .dma_tdata, .dma_tvalid(s_valid[N-1:0]), .dma_tlast(s_last[N-1:0]), .dma_tready,
    .cpl_tdata, .cpl_tvalid(s_valid[N]), .cpl_tlast(s_last[N]), .cpl_tready,
    .rrq_tdata, .rrq_tvalid(s_valid[N+1]), .rrq_tlast(s_last[N+1]), .rrq_tready,
    .m_tdata, .m_tvalid, .m_tlast, .m_tready
  );

  logic [DW-1:0] nq_tdata;
  logic [N-1:0]  nq_dready;
  logic          nq_cready, nq_rready, nq_tvalid, nq_tlast;
  logic          nq_rvalid = 1'b0;

  tx_port_arbiter #(.NUM_DMA(N), .DW(DW), .HAS_RDREQ(1'b0)) dut_norq (
    .clk, .rst_n,
    .dma_tdata('0), .dma_tvalid('0), .dma_tlast('0), .dma_tready(nq_dready),
    .cpl_tdata('0), .cpl_tvalid(1'b0), .cpl_tlast(1'b0), .cpl_tready(nq_cready),
    .rrq_tdata(64'h55), .rrq_tvalid(nq_rvalid), .rrq_tlast(1'b1), .rrq_tready(nq_rready),
    .m_tdata(nq_tdata), .m_tvalid(nq_tvalid), .m_tlast(nq_tlast), .m_tready(1'b1)
  );

  // producer models: advance only on a handshake
  always @(posedge clk) begin
    for (int i = 0; i < N + 2; i++) begin
      if (s_valid[i] && rdy[i]) begin
        if (s_left[i] == 1) s_valid[i] <= 1'b0;
        s_left[i] <= s_left[i] - 1;
        s_beat[i] <= s_beat[i] + 8'd1;
      end
    end
  end

  int cyc = 0;
  int n_log = 0;
  int log_src [64];
  int log_cyc [64];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (m_tvalid && m_tready && n_log < 64) begin
      log_src[n_log] = int'(m_tdata[15:8]);
      log_cyc[n_log] = cyc;
      n_log = n_log + 1;
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(int src, int len);
    s_valid[src] = 1'b1;
    s_left[src]  = len;
    s_beat[src]  = 8'd0;
  endtask

  task automatic drive_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    while (s_valid != '0) drive_edge();
    drive_edge();
  endtask

  task automatic expect_seq(string req, int exp[]);
    chk(req, "beat count", n_log, exp.size());
    foreach (exp[i])
      if (i < n_log) chk(req, $sformatf("beat %0d source", i), log_src[i], exp[i]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "m_tvalid idle", m_tvalid, 0);
    chk("R1", "ready vector idle", rdy, 0);
  endtask

  task automatic t_priority();
    m_tready = 1'b1;
    n_log = 0;
    launch(2, 2); launch(N+1, 2); launch(N, 2);
    wait_idle();
    expect_seq("R2", '{N, N, N+1, N+1, 2, 2});
    chk("R3", "read request before channel", log_src[2], N+1);
    for (int i = 1; i < 6; i++)
      chk("R9", "no gap between beats", log_cyc[i] - log_cyc[0], i);
  endtask

  task automatic t_round_robin();
    n_log = 0;
    launch(1, 1); launch(3, 1); launch(5, 1);
    wait_idle();
    expect_seq("R4", '{3, 5, 1});
    n_log = 0;
    for (int i = 0; i < N; i++) launch(i, 1);
    wait_idle();
    expect_seq("R4", '{2, 3, 4, 5, 6, 7, 0, 1});
  endtask

  task automatic t_atomic();
    n_log = 0;
    launch(0, 4);
    drive_edge();
    launch(N, 1);
    launch(N+1, 1);
    @(negedge clk);
    chk("R5", "completion not ready mid-packet", cpl_tready, 0);
    wait_idle();
    expect_seq("R5", '{0, 0, 0, 0, N, N+1});
  endtask

  task automatic t_backpressure();
    n_log = 0;
    m_tready = 1'b0;
    launch(6, 2);
    drive_edge();
    launch(N, 1);
    @(negedge clk);
    chk("R6", "offered source held", m_tdata[15:8], 6);
    chk("R6", "m_tvalid held", m_tvalid, 1);
    chk("R7", "ready vector while port stalled", rdy, 0);
    drive_edge();
    m_tready = 1'b1;
    @(negedge clk);
    chk("R7", "only channel 6 ready", rdy, 1 << 6);
    chk("R9", "data passes through", m_tdata[7:0], 0);
    chk("R9", "last flag clear on first beat", m_tlast, 0);
    wait_idle();
    expect_seq("R6", '{6, 6, N});
  endtask

  task automatic t_no_rdreq();
    nq_rvalid = 1'b1;
    drive_edge();
    drive_edge();
    @(negedge clk);
    chk("R8", "read request ignored: m_tvalid", nq_tvalid, 0);
    chk("R8", "read request ignored: ready", nq_rready, 0);
    nq_rvalid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N + 2; i++) begin
      s_left[i] = 0;
      s_beat[i] = 8'd0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    drive_edge();
    t_priority();
    t_round_robin();
    t_atomic();
    t_backpressure();
    t_no_rdreq();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule